// File: doc/BRIEF.md
# Slot-Enabled Serial Buffer Sequencer

This block sits between a serial audio frame controller and a host. The frame controller marks the start of each time slot and each serial bit. The sequencer decides, per slot, whether that slot carries data. Each direction has its own 16-bit slot-enable mask, and mask bit n governs slot n. When a transmit slot is enabled, the block loads the next of four 16-bit transmit buffers into a shifter. When a receive slot is enabled, the block fills the next of four receive buffers. A buffer index moves only on enabled slots, so a codec word wider than 16 bits can be spread over consecutive slots and consecutive buffers.

A buffer-length code sets how many words make up one buffer event. The transmit and receive indices each wrap back to 0 after that many words, and each raises a one-cycle done pulse when it wraps. The host fills the transmit buffers through a valid/ready write port. It reads the receive buffers through a plain combinational read port.

The write port applies back-pressure for one reason only. In a cycle where a transmit load reads a buffer, a write aimed at that same buffer is held off with `wr_ready` low, so the load sees the old contents. The host keeps `wr_valid`, `wr_addr` and `wr_data` steady until it sees `wr_ready` high. A write is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high.

Top module: `slot_buf_seq`

## Requirements
- R1: After reset: `sdo`, `tx_done` and `rx_done` are 0; `wr_ready` is 1 when no slot starts; every buffer reads 0; both indices are 0.
- R2: A transmit slot is enabled when `tx_slot_mask[slot_idx]` is 1 in the `slot_start` cycle. For such a slot, the low `word_size_m1+1` bits of transmit buffer `tx_idx` appear on `sdo`, most significant bit first. The first bit shows from the cycle after `slot_start`, and each `bit_en` cycle moves to the next bit. Zeros follow the last bit.
- R3: A disabled transmit slot drives `sdo` to 0 for the whole slot and leaves the transmit index unchanged.
- R4: In an enabled receive slot (`rx_slot_mask[slot_idx]` is 1), the first `word_size_m1+1` `sdi` bits sampled on `bit_en` are gathered MSB first. They are written into the low bits of receive buffer `rx_idx`, with the upper bits cleared, at the last of those bits. The index then advances. Later bits in the slot are ignored.
- R5: A disabled receive slot writes no receive buffer and leaves the receive index unchanged.
- R6: The length code `buf_len` gives the number of words per event: 00 gives 1, 01 gives 2, 10 gives 3, 11 gives 4. An index that has reached (or passed) `buf_len` returns to 0 on its next advance; otherwise it steps by one.
- R7: `tx_done` is high for exactly the one cycle after a `slot_start` whose load wraps the transmit index. `rx_done` is high for exactly the one cycle after the `bit_en` whose write wraps the receive index.
- R8: `wr_ready` is low only in a `slot_start` cycle of an enabled transmit slot whose `wr_addr` equals the buffer being loaded. A held write does not change that buffer. An accepted write is used by every later load.
- R9: `rd_data` always shows receive buffer `rd_addr`.
- R10: Long words can be packed across slots. With mask 0x0003, code 01 and 16-bit words, a 24-bit value travels as its top 16 bits from buffer 0, then its low 8 bits left-justified from buffer 1. With mask 0x0007, code 10 and 8-bit words, it travels as three bytes from buffers 0 to 2. Received words land in the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_slot_mask | input | 16 | Transmit slot enables, bit n for slot n |
| rx_slot_mask | input | 16 | Receive slot enables, bit n for slot n |
| buf_len | input | 2 | Words per buffer event, minus one |
| word_size_m1 | input | 4 | Serial word size minus one |
| slot_start | input | 1 | One-cycle strobe at the start of a slot |
| slot_idx | input | 4 | Number of the slot that is starting |
| bit_en | input | 1 | One serial bit per cycle it is high |
| sdi | input | 1 | Serial receive data, sampled on `bit_en` |
| sdo | output | 1 | Serial transmit data |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write can be taken this cycle |
| wr_addr | input | 2 | Transmit buffer to write |
| wr_data | input | 16 | Transmit buffer write data |
| rd_addr | input | 2 | Receive buffer to read |
| rd_data | output | 16 | Receive buffer contents |
| tx_done | output | 1 | Transmit index wrapped |
| rx_done | output | 1 | Receive index wrapped |

## Verification
The assertions assume that `slot_start` and `bit_en` are never high in the same cycle. They also assume that the masks, the length code and the word size change only between slots. The stimulus keeps to this by starting every slot alone in its cycle, then giving exactly sixteen back-to-back bit strobes. Configuration and host writes change only in the idle gaps between slots. Random frames mix masks, word sizes from 1 to 16 and all four length codes. Directed cases cover the held write and both long-word packings.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  localparam int unsigned SEQ_W     = 16;
  localparam int unsigned SEQ_NBUF  = 4;
  localparam int unsigned SEQ_NSLOT = 16;

  // next buffer index: wrap to 0 once the last word of an event is reached
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned last);
    return (idx >= last) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/slot_seq_index.sv
module slot_seq_index #(
  parameter int unsigned NBUF = slot_seq_pkg::SEQ_NBUF,
  localparam int unsigned IDXW = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [IDXW-1:0] last,
  output logic [IDXW-1:0] idx,
  output logic            wrap_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= adv && (idx >= last);
      if (adv) idx <= IDXW'(slot_seq_pkg::wrap_next(int'(idx), int'(last)));
    end
  end
endmodule

// File: rtl/slot_seq_tx.sv
module slot_seq_tx #(
  parameter int unsigned W    = slot_seq_pkg::SEQ_W,
  parameter int unsigned NBUF = slot_seq_pkg::SEQ_NBUF,
  localparam int unsigned IDXW = $clog2(NBUF),
  localparam int unsigned WSW  = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            start,
  input  logic            start_en,
  input  logic [IDXW-1:0] load_idx,
  input  logic [WSW-1:0]  ws_m1,
  input  logic            bit_en,
  output logic            sdo
);
  logic [W-1:0] mem [NBUF];
  logic [W-1:0] shreg;
  logic [W-1:0] aligned;

  // left-align the low ws bits; bits above the word size shift out
  assign aligned = mem[load_idx] << (WSW'(W-1) - ws_m1);
  assign sdo     = shreg[W-1];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (wr_en && wr_addr == IDXW'(g))   mem[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shreg <= '0;
    else if (start)   shreg <= start_en ? aligned : '0;
    else if (bit_en)  shreg <= {shreg[W-2:0], 1'b0};
  end
endmodule

// File: rtl/slot_seq_rx.sv
module slot_seq_rx #(
  parameter int unsigned W    = slot_seq_pkg::SEQ_W,
  parameter int unsigned NBUF = slot_seq_pkg::SEQ_NBUF,
  localparam int unsigned IDXW = $clog2(NBUF),
  localparam int unsigned WSW  = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_en,
  input  logic            bit_en,
  input  logic            sdi,
  input  logic [WSW-1:0]  ws_m1,
  input  logic [IDXW-1:0] wr_idx,
  output logic            cap_done,
  input  logic [IDXW-1:0] rd_addr,
  output logic [W-1:0]    rd_data
);
  logic [W-1:0] mem [NBUF];
  logic [W-1:0] shreg;
  logic [WSW:0] cnt;
  logic         active;
  logic         take;
  logic [W-1:0] word_in;

  assign take     = active && bit_en && (cnt <= {1'b0, ws_m1});
  assign cap_done = take && (cnt == {1'b0, ws_m1});
  assign word_in  = {shreg[W-2:0], sdi};
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (start) begin
      active <= start_en;
      cnt    <= '0;
      shreg  <= '0;
    end else if (take) begin
      cnt    <= cnt + 1'b1;
      shreg  <= word_in;
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (cap_done && wr_idx == IDXW'(g)) mem[g] <= word_in;
    end
  end
endmodule

// File: rtl/slot_buf_seq.sv
module slot_buf_seq #(
  parameter int unsigned W     = slot_seq_pkg::SEQ_W,
  parameter int unsigned NBUF  = slot_seq_pkg::SEQ_NBUF,
  parameter int unsigned NSLOT = slot_seq_pkg::SEQ_NSLOT,
  localparam int unsigned IDXW  = $clog2(NBUF),
  localparam int unsigned WSW   = $clog2(W),
  localparam int unsigned SLOTW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] tx_slot_mask,
  input  logic [NSLOT-1:0] rx_slot_mask,
  input  logic [IDXW-1:0]  buf_len,
  input  logic [WSW-1:0]   word_size_m1,
  input  logic             slot_start,
  input  logic [SLOTW-1:0] slot_idx,
  input  logic             bit_en,
  input  logic             sdi,
  output logic             sdo,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [IDXW-1:0]  wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [IDXW-1:0]  rd_addr,
  output logic [W-1:0]     rd_data,
  output logic             tx_done,
  output logic             rx_done
);
  logic            tx_load;
  logic            rx_cap;
  logic [IDXW-1:0] tx_idx;
  logic [IDXW-1:0] rx_idx;

  assign tx_load  = slot_start && tx_slot_mask[slot_idx];
  // a write to the buffer being loaded waits one cycle
  assign wr_ready = !(tx_load && wr_addr == tx_idx);

  slot_seq_index #(.NBUF(NBUF)) u_tx_index (
    .clk(clk), .rst_n(rst_n), .adv(tx_load), .last(buf_len),
    .idx(tx_idx), .wrap_pulse(tx_done)
  );

  slot_seq_index #(.NBUF(NBUF)) u_rx_index (
    .clk(clk), .rst_n(rst_n), .adv(rx_cap), .last(buf_len),
    .idx(rx_idx), .wrap_pulse(rx_done)
  );

  slot_seq_tx #(.W(W), .NBUF(NBUF)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_valid && wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(slot_start), .start_en(tx_load), .load_idx(tx_idx),
    .ws_m1(word_size_m1), .bit_en(bit_en), .sdo(sdo)
  );

  slot_seq_rx #(.W(W), .NBUF(NBUF)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .start(slot_start), .start_en(rx_slot_mask[slot_idx]),
    .bit_en(bit_en), .sdi(sdi), .ws_m1(word_size_m1),
    .wr_idx(rx_idx), .cap_done(rx_cap),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/slot_buf_seq_chk.sv
module slot_buf_seq_chk #(
  parameter int unsigned NBUF  = slot_seq_pkg::SEQ_NBUF,
  parameter int unsigned NSLOT = slot_seq_pkg::SEQ_NSLOT,
  localparam int unsigned IDXW  = $clog2(NBUF),
  localparam int unsigned SLOTW = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] tx_slot_mask,
  input logic             slot_start,
  input logic [SLOTW-1:0] slot_idx,
  input logic             bit_en,
  input logic             sdo,
  input logic             wr_ready,
  input logic             tx_done,
  input logic             rx_done,
  input logic [IDXW-1:0]  tx_idx,
  input logic [IDXW-1:0]  rx_idx
);
  // input rule: a slot start never shares a cycle with a bit strobe (R2)
  p_start_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_start && bit_en));

  p_tx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && !tx_slot_mask[slot_idx] |=> !sdo);

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_start && tx_slot_mask[slot_idx]) |=> $stable(tx_idx));

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(rx_idx));

  p_tx_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_idx == '0);

  p_tx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(slot_start));

  p_rx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(bit_en) && rx_idx == '0);

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |-> wr_ready);
endmodule

bind slot_buf_seq slot_buf_seq_chk #(.NBUF(NBUF), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_slot_mask(tx_slot_mask),
  .slot_start(slot_start), .slot_idx(slot_idx), .bit_en(bit_en),
  .sdo(sdo), .wr_ready(wr_ready), .tx_done(tx_done), .rx_done(rx_done),
  .tx_idx(tx_idx), .rx_idx(rx_idx)
);

// File: tb/tb_slot_buf_seq.sv
`timescale 1ns/1ps
module tb_slot_buf_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_slot_mask = '0, rx_slot_mask = '0;
  logic [1:0]  buf_len = '0;
  logic [3:0]  word_size_m1 = 4'hF;
  logic        slot_start = 1'b0, bit_en = 1'b0, sdi = 1'b0;
  logic [3:0]  slot_idx = '0;
  logic        sdo, wr_ready, tx_done, rx_done;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;

  always #2.5 clk = ~clk;

  slot_buf_seq dut (
    .clk(clk), .rst_n(rst_n), .tx_slot_mask(tx_slot_mask), .rx_slot_mask(rx_slot_mask),
    .buf_len(buf_len), .word_size_m1(word_size_m1), .slot_start(slot_start),
    .slot_idx(slot_idx), .bit_en(bit_en), .sdi(sdi), .sdo(sdo),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_done(tx_done), .rx_done(rx_done)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_tx [4];
  logic [15:0] m_rx [4];
  int m_tidx, m_ridx, m_len, m_ws;

  function automatic int nxt(int idx, int last);
    return (idx >= last) ? 0 : idx + 1;
  endfunction
  function automatic logic [15:0] exp_tx_word(logic [15:0] b, int ws);
    return b << (16 - ws);
  endfunction
  function automatic logic [15:0] exp_rx_word(logic [15:0] w, int ws);
    return w >> (16 - ws);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
    m_tidx = 0; m_ridx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(logic [15:0] tm, logic [15:0] rm, int len, int ws);
    @(negedge clk);
    tx_slot_mask = tm; rx_slot_mask = rm;
    buf_len = 2'(len); word_size_m1 = 4'(ws - 1);
    m_len = len; m_ws = ws;
  endtask

  task automatic host_wr(int a, logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 2'(a); wr_data = d;
    #1 check(wr_ready == 1'b1, "R8 idle write ready", int'(wr_ready), 1);
    @(negedge clk);
    wr_valid = 1'b0;
    m_tx[a] = d;
  endtask

  task automatic check_rx_bufs(string req);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1 check(rd_data == m_rx[a], req, int'(rd_data), int'(m_rx[a]));
    end
  endtask

  // one slot: start strobe then sixteen bit strobes; returns the serial word seen
  task automatic run_slot(int s, logic [15:0] rxw, output logic [15:0] got);
    bit ten = tx_slot_mask[s];
    bit ren = rx_slot_mask[s];
    logic [15:0] ex = ten ? exp_tx_word(m_tx[m_tidx], m_ws) : 16'h0;
    bit exp_td = ten && (m_tidx >= m_len);
    bit exp_rd = ren && (m_ridx >= m_len);
    int rd_cnt = 0;
    if (ten) m_tidx = nxt(m_tidx, m_len);
    @(negedge clk);
    slot_start = 1'b1; slot_idx = 4'(s);
    @(negedge clk);
    slot_start = 1'b0;
    check(tx_done == exp_td, "R7 tx_done after load", int'(tx_done), int'(exp_td));
    got = '0;
    for (int b = 0; b < 16; b++) begin
      got = {got[14:0], sdo};
      bit_en = 1'b1; sdi = rxw[15-b];
      @(negedge clk);
      if (rx_done) rd_cnt++;
      if (b == 0) check(tx_done == 1'b0, "R7 tx_done one cycle", int'(tx_done), 0);
    end
    bit_en = 1'b0;
    check(got == ex, ten ? "R2 tx serial word" : "R3 disabled slot zeros", int'(got), int'(ex));
    if (ren) begin
      m_rx[m_ridx] = exp_rx_word(rxw, m_ws);
      m_ridx = nxt(m_ridx, m_len);
    end
    check(rd_cnt == int'(exp_rd), "R7 rx_done count", rd_cnt, int'(exp_rd));
    check_rx_bufs(ren ? "R4 rx capture / R9 read" : "R5 disabled rx slot");
  endtask

  logic [15:0] g0, g1, g2;

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m_len = 0; m_ws = 16;
    do_reset();
    // R1 reset state
    check(sdo == 1'b0, "R1 sdo reset", int'(sdo), 0);
    check(tx_done == 1'b0 && rx_done == 1'b0, "R1 done reset", int'({tx_done, rx_done}), 0);
    check(wr_ready == 1'b1, "R1 wr_ready reset", int'(wr_ready), 1);
    check_rx_bufs("R1 rx buffers reset");

    // R10 packing, 16-bit words over two slots
    set_cfg(16'h0003, 16'h0003, 1, 16);
    host_wr(0, 16'hABCD); host_wr(1, 16'hEF00);
    run_slot(0, 16'h1234, g0); run_slot(1, 16'h5600, g1);
    check({g0, g1[15:8]} == 24'hABCDEF, "R10 packed tx 16+8", int'({g0, g1[15:8]}), 24'hABCDEF);
    rd_addr = 2'd0; #1 g0 = rd_data; rd_addr = 2'd1; #1 g1 = rd_data;
    check({g0, g1[15:8]} == 24'h123456, "R10 packed rx 16+8", int'({g0, g1[15:8]}), 24'h123456);

    // R10 packing, three bytes
    set_cfg(16'h0007, 16'h0007, 2, 8);
    host_wr(0, 16'h00AB); host_wr(1, 16'h00CD); host_wr(2, 16'h00EF);
    run_slot(0, 16'h1200, g0); run_slot(1, 16'h3400, g1); run_slot(2, 16'h5600, g2);
    check({g0[15:8], g1[15:8], g2[15:8]} == 24'hABCDEF, "R10 packed tx bytes",
          int'({g0[15:8], g1[15:8], g2[15:8]}), 24'hABCDEF);
    check_rx_bufs("R10 packed rx bytes");

    // R8 held write during the load of the addressed buffer
    do_reset();
    set_cfg(16'h0001, 16'h0000, 0, 16);
    host_wr(0, 16'h1111);
    @(negedge clk);
    slot_start = 1'b1; slot_idx = 4'd0;
    wr_valid = 1'b1; wr_addr = 2'd1; wr_data = 16'h3333;
    #1 check(wr_ready == 1'b1, "R8 other buffer accepted", int'(wr_ready), 1);
    wr_addr = 2'd0; wr_data = 16'h2222;
    #1 check(wr_ready == 1'b0, "R8 same buffer held", int'(wr_ready), 0);
    @(negedge clk);
    slot_start = 1'b0;
    #1 check(wr_ready == 1'b1, "R8 held write retried", int'(wr_ready), 1);
    @(negedge clk);
    wr_valid = 1'b0;
    g0 = '0;
    for (int b = 0; b < 16; b++) begin
      g0 = {g0[14:0], sdo}; bit_en = 1'b1; @(negedge clk);
    end
    bit_en = 1'b0;
    check(g0 == 16'h1111, "R8 load saw old data", int'(g0), 16'h1111);
    m_tx[0] = 16'h2222;
    run_slot(0, 16'h0, g0);
    check(g0 == 16'h2222, "R8 accepted write used", int'(g0), 16'h2222);

    // random frames (R2 R3 R4 R5 R6 R7 R9)
    for (int f = 0; f < 40; f++) begin
      set_cfg(16'($urandom), 16'($urandom), int'($urandom % 4), 1 + int'($urandom % 16));
      for (int w = 0; w < 3; w++) host_wr(int'($urandom % 4), 16'($urandom));
      for (int s = 0; s < 16; s++) run_slot(s, 16'($urandom), g0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule